// File: doc/BRIEF.md
# Exception Entry and Register Banking Unit

This unit performs the processor-side work of taking an exception. It takes a request that carries one of four type codes: privileged call, instruction abort, data abort or interrupt. From the current status word it works out the current mode. If the target mode differs, it moves the live copies of r29, r30 and the saved-status register into the bank of the outgoing mode. It then loads the bank of the incoming mode. It also forms the new status word, captures the return address and produces the vector address for the program counter. The unit holds the banked copies itself. The live registers enter as inputs, and the updated values leave on registered outputs, which are qualified by a one-cycle `done` pulse.

The same banking path also serves a plain mode-switch request. This is the transfer a status write or an exception return needs. It moves the banks and rewrites the mode field without entering a vector. Several modes can share one bank, so the unit also handles switches between two modes that use the same bank. A request with an unknown current mode, an unknown exception type or an unknown switch target produces an `err` pulse and changes nothing.

Top module: `exc_entry`

## Requirements
- R1: After a synchronous active-low reset, `done` and `err` are low, every data output is zero and every banked copy is zero.
- R2: The modes are encoded in status bits [4:0] and map to banks as follows. USER 0x10 and SUSR 0x1F share bank 0. PRIV 0x13 uses bank 1, TRAP 0x17 bank 2, EXTN 0x1B bank 3 and INTR 0x12 bank 4. Any other code is unknown.
- R3: Each exception type code selects a target mode and a vector offset. Code 0 (privileged call) selects PRIV at 0x08. Code 1 (instruction abort) selects TRAP at 0x0C. Code 2 (data abort) selects TRAP at 0x10. Code 3 (interrupt) selects INTR at 0x18. Codes 4 to 7 are unknown.
- R4: When `hivec` is high, the vector address is the offset plus 0xFFFF0000. When `hivec` is low, it is the offset alone.
- R5: On exception entry, `out_bsr` is the full status word from before entry. `out_status` is that word with bits [4:0] replaced by the target mode and bit 7 (interrupt disable) set. All other bits are kept.
- R6: On exception entry, `out_r30` equals `cur_pc` unmodified and `out_pc` equals the vector address.
- R7: When the target mode differs from the current mode, `cur_r29`, `cur_r30` and `cur_bsr` are stored into the bank of the current mode. The target mode's bank then supplies r29 on exception entry, and r29, r30 and the saved status on a plain switch. If both modes share a bank, the values just stored are the ones supplied.
- R8: When the target mode equals the current mode, no bank is written and the live r29, r30 and saved status pass through unchanged.
- R9: A plain switch (`sw_req`, target `sw_mode`) drives `out_status` as the current status with bits [4:0] replaced by the target. `out_pc` equals `cur_pc`, and the interrupt-disable bit is not touched.
- R10: Each sampled request gives exactly one `done` or `err` pulse in the following cycle. No pulse appears in a cycle after no request.
- R11: An unknown current mode, an unknown exception type or an unknown switch target raises `err` instead of `done`. Such a request leaves every output and every bank unchanged.
- R12: When `exc_req` and `sw_req` are sampled together, only the exception is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception entry request |
| exc_type | input | 3 | Exception type code |
| sw_req | input | 1 | Plain mode-switch request |
| sw_mode | input | 5 | Target mode for a plain switch |
| hivec | input | 1 | High-vector control bit |
| cur_status | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| cur_r29 | input | 32 | Live r29 |
| cur_r30 | input | 32 | Live r30 |
| cur_bsr | input | 32 | Live saved-status register |
| done | output | 1 | Update valid pulse |
| err | output | 1 | Rejected request pulse |
| out_status | output | 32 | New status word |
| out_pc | output | 32 | New program counter |
| out_r29 | output | 32 | New r29 |
| out_r30 | output | 32 | New r30 |
| out_bsr | output | 32 | New saved-status register |

## Verification
Exception entry is tried from every known mode, with all four type codes and with both settings of `hivec`. The model's banks carry over from one entry to the next. This separates mode-to-bank aliasing, vector selection, high relocation and the same-mode pass-through. Next, a full 6-by-6 sweep of plain switches reads r30 and the saved status back out of the banks, which shows that earlier stores landed in the right bank. This sweep includes the USER/SUSR pair, which shares bank 0. Unknown type codes, unknown current modes and unknown targets, together with simultaneous requests, separate the rejection path and the priority order from normal entry.

// File: rtl/exc_pkg.sv
// Shared constants for the exception entry unit: mode codes, exception
// type codes and vector offsets. Assumes modes live in status bits [4:0].
package exc_pkg;
    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 5;

    localparam logic [MODE_W-1:0] MD_USER = 5'h10;
    localparam logic [MODE_W-1:0] MD_SUSR = 5'h1F;
    localparam logic [MODE_W-1:0] MD_PRIV = 5'h13;
    localparam logic [MODE_W-1:0] MD_TRAP = 5'h17;
    localparam logic [MODE_W-1:0] MD_EXTN = 5'h1B;
    localparam logic [MODE_W-1:0] MD_INTR = 5'h12;

    typedef enum logic [2:0] {
        EX_PCALL = 3'd0,
        EX_IABT  = 3'd1,
        EX_DABT  = 3'd2,
        EX_IRQ   = 3'd3
    } exc_kind_e;

    localparam logic [7:0] OFS_PCALL = 8'h08;
    localparam logic [7:0] OFS_IABT  = 8'h0C;
    localparam logic [7:0] OFS_DABT  = 8'h10;
    localparam logic [7:0] OFS_IRQ   = 8'h18;
endpackage

// File: rtl/exc_bank_map.sv
// Mode-to-bank decoder. Several modes may share one bank; an unknown
// mode code clears ok. Purely combinational.
module exc_bank_map
    import exc_pkg::*;
#(
    parameter int NBANK  = NUM_BANKS,
    localparam int BIDX_W = $clog2(NBANK)
) (
    input  logic [MODE_W-1:0] mode,
    output logic [BIDX_W-1:0] idx,
    output logic              ok
);
    // Decode a mode code into its bank index.
    always_comb begin
        ok  = 1'b1;
        idx = '0;
        case (mode)
            MD_USER, MD_SUSR: idx = BIDX_W'(0);
            MD_PRIV:          idx = BIDX_W'(1);
            MD_TRAP:          idx = BIDX_W'(2);
            MD_EXTN:          idx = BIDX_W'(3);
            MD_INTR:          idx = BIDX_W'(4);
            default:          ok  = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_vector.sv
// Exception type decoder: picks the target mode and vector address.
// The high-vector bit adds a fixed base. Unknown types clear ok.
module exc_vector
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic [2:0]        kind,
    input  logic              hivec,
    output logic [MODE_W-1:0] tgt_mode,
    output logic [DATA_W-1:0] vec_addr,
    output logic              ok
);
    logic [7:0] ofs;

    // Map each known exception type onto its mode and offset.
    always_comb begin
        ok       = 1'b1;
        tgt_mode = MD_USER;
        ofs      = '0;
        case (kind)
            EX_PCALL: begin tgt_mode = MD_PRIV; ofs = OFS_PCALL; end
            EX_IABT:  begin tgt_mode = MD_TRAP; ofs = OFS_IABT;  end
            EX_DABT:  begin tgt_mode = MD_TRAP; ofs = OFS_DABT;  end
            EX_IRQ:   begin tgt_mode = MD_INTR; ofs = OFS_IRQ;   end
            default:  ok = 1'b0;
        endcase
    end

    // Relocate the vector when the high-vector bit is set.
    always_comb begin
        vec_addr = DATA_W'(ofs) + (hivec ? HIGH_BASE : '0);
    end
endmodule

// File: rtl/exc_bank_store.sv
// Banked copies of r29, r30 and saved status, one set per bank.
// One write port and one read port; a read of the bank being written
// in the same cycle returns the write data.
module exc_bank_store #(
    parameter int DATA_W = 32,
    parameter int NBANK  = 5,
    localparam int BIDX_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_r29,
    input  logic [DATA_W-1:0] wr_r30,
    input  logic [DATA_W-1:0] wr_bsr,
    input  logic [BIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_r29,
    output logic [DATA_W-1:0] rd_r30,
    output logic [DATA_W-1:0] rd_bsr
);
    logic [DATA_W-1:0] bk_r29 [NBANK];
    logic [DATA_W-1:0] bk_r30 [NBANK];
    logic [DATA_W-1:0] bk_bsr [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Store one bank's copies when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bk_r29[g] <= '0;
                bk_r30[g] <= '0;
                bk_bsr[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                bk_r29[g] <= wr_r29;
                bk_r30[g] <= wr_r30;
                bk_bsr[g] <= wr_bsr;
            end
        end
    end

    // Read the selected bank, forwarding a same-cycle write.
    always_comb begin
        rd_r29 = '0;
        rd_r30 = '0;
        rd_bsr = '0;
        if (wr_en && (wr_idx == rd_idx)) begin
            rd_r29 = wr_r29;
            rd_r30 = wr_r30;
            rd_bsr = wr_bsr;
        end else begin
            for (int i = 0; i < NBANK; i++) begin
                if (int'(rd_idx) == i) begin
                    rd_r29 = bk_r29[i];
                    rd_r30 = bk_r30[i];
                    rd_bsr = bk_bsr[i];
                end
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NBANK)); // R2
endmodule

// File: rtl/exc_entry.sv
// Exception entry and register banking. Takes an exception or plain
// mode-switch request, performs the bank transfer and produces the new
// status, PC, r29, r30 and saved status one cycle later with a done
// pulse. Assumes at most one operation per cycle; an exception wins
// over a simultaneous switch. Unknown codes give err and no change.
module exc_entry
    import exc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IRQ_OFF_BIT = 7,
    parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000,
    localparam int BIDX_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [2:0]        exc_type,
    input  logic              sw_req,
    input  logic [MODE_W-1:0] sw_mode,
    input  logic              hivec,
    input  logic [DATA_W-1:0] cur_status,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] cur_r29,
    input  logic [DATA_W-1:0] cur_r30,
    input  logic [DATA_W-1:0] cur_bsr,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] out_status,
    output logic [DATA_W-1:0] out_pc,
    output logic [DATA_W-1:0] out_r29,
    output logic [DATA_W-1:0] out_r30,
    output logic [DATA_W-1:0] out_bsr
);
    logic [MODE_W-1:0] old_mode, exc_mode, tgt_mode;
    logic [BIDX_W-1:0] old_idx, new_idx;
    logic              old_ok, new_ok, type_ok, op_ok, go, same_mode, xfer;
    logic [DATA_W-1:0] vec_addr, rd_r29, rd_r30, rd_bsr;
    logic [DATA_W-1:0] ld_r29, ld_r30, ld_bsr, repl_status;
    logic [DATA_W-1:0] nx_status, nx_pc, nx_r29, nx_r30, nx_bsr;

    assign old_mode = cur_status[MODE_W-1:0];
    assign go       = exc_req || sw_req;

    exc_bank_map #(.NBANK(NUM_BANKS)) u_old_map (
        .mode (old_mode),
        .idx  (old_idx),
        .ok   (old_ok)
    );

    exc_vector #(.DATA_W(DATA_W), .HIGH_BASE(HIGH_BASE)) u_vec (
        .kind     (exc_type),
        .hivec    (hivec),
        .tgt_mode (exc_mode),
        .vec_addr (vec_addr),
        .ok       (type_ok)
    );

    // Choose the target mode: exception first, then plain switch.
    always_comb begin
        tgt_mode = exc_req ? exc_mode : sw_mode;
    end

    exc_bank_map #(.NBANK(NUM_BANKS)) u_new_map (
        .mode (tgt_mode),
        .idx  (new_idx),
        .ok   (new_ok)
    );

    // Qualify the request and decide whether a bank transfer happens.
    always_comb begin
        op_ok     = old_ok && new_ok && (!exc_req || type_ok);
        same_mode = (tgt_mode == old_mode);
        xfer      = go && op_ok && !same_mode;
    end

    exc_bank_store #(.DATA_W(DATA_W), .NBANK(NUM_BANKS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (xfer),
        .wr_idx (old_idx),
        .wr_r29 (cur_r29),
        .wr_r30 (cur_r30),
        .wr_bsr (cur_bsr),
        .rd_idx (new_idx),
        .rd_r29 (rd_r29),
        .rd_r30 (rd_r30),
        .rd_bsr (rd_bsr)
    );

    // Pick banked or live values, then build the next register set.
    always_comb begin
        ld_r29      = same_mode ? cur_r29 : rd_r29;
        ld_r30      = same_mode ? cur_r30 : rd_r30;
        ld_bsr      = same_mode ? cur_bsr : rd_bsr;
        repl_status = {cur_status[DATA_W-1:MODE_W], tgt_mode};
        if (exc_req) begin
            nx_status              = repl_status;
            nx_status[IRQ_OFF_BIT] = 1'b1;
            nx_bsr                 = cur_status;
            nx_r30                 = cur_pc;
            nx_r29                 = ld_r29;
            nx_pc                  = vec_addr;
        end else begin
            nx_status = repl_status;
            nx_bsr    = ld_bsr;
            nx_r30    = ld_r30;
            nx_r29    = ld_r29;
            nx_pc     = cur_pc;
        end
    end

    // Register the outcome pulses and, on success, the new registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            err        <= 1'b0;
            out_status <= '0;
            out_pc     <= '0;
            out_r29    <= '0;
            out_r30    <= '0;
            out_bsr    <= '0;
        end else begin
            done <= go && op_ok;
            err  <= go && !op_ok;
            if (go && op_ok) begin
                out_status <= nx_status;
                out_pc     <= nx_pc;
                out_r29    <= nx_r29;
                out_r30    <= nx_r30;
                out_bsr    <= nx_bsr;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R11
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (done ^ err)); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !(done || err)); // R10
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(out_pc) && $stable(out_r29) && $stable(out_status))); // R11
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(exc_req)) |-> out_status[IRQ_OFF_BIT]); // R5
    AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(exc_req)) |-> (out_r30 == $past(cur_pc))); // R6
    AST_SW_PC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(sw_req && !exc_req)) |-> (out_pc == $past(cur_pc))); // R9
endmodule

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, sw_req = 1'b0, hivec = 1'b0;
    logic [2:0]  exc_type = '0;
    logic [4:0]  sw_mode = '0;
    logic [31:0] cur_status = '0, cur_pc = '0, cur_r29 = '0, cur_r30 = '0, cur_bsr = '0;
    logic        done, err;
    logic [31:0] out_status, out_pc, out_r29, out_r30, out_bsr;

    int checks = 0, errors = 0, seq = 0;
    logic [31:0] m_r29 [5], m_r30 [5], m_bsr [5];
    logic [31:0] e_status = '0, e_pc = '0, e_r29 = '0, e_r30 = '0, e_bsr = '0;
    logic [4:0]  modes [6] = '{5'h10, 5'h1F, 5'h13, 5'h17, 5'h1B, 5'h12};

    always #10 clk = ~clk; // 50 MHz

    exc_entry dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .sw_req(sw_req), .sw_mode(sw_mode), .hivec(hivec),
        .cur_status(cur_status), .cur_pc(cur_pc), .cur_r29(cur_r29),
        .cur_r30(cur_r30), .cur_bsr(cur_bsr), .done(done), .err(err),
        .out_status(out_status), .out_pc(out_pc), .out_r29(out_r29),
        .out_r30(out_r30), .out_bsr(out_bsr)
    );

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h10, 5'h1F: return 0;
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request: drive at negedge, check the registered result one cycle later,
    // then check that an idle cycle raises no pulse (R10).
    task automatic op(input bit is_exc, input bit also_sw, input logic [2:0] typ,
                      input logic [4:0] smode, input logic [4:0] oldm, input bit hv);
        logic [4:0]  tgt;
        logic [31:0] vec, st;
        int ob, nb;
        bit ok;
        seq++;
        st = {24'hC3A500 ^ 24'(seq * 24'h010203), 3'b010, oldm};
        @(negedge clk);
        cur_status = st;
        cur_pc  = 32'h0000_4000 + 32'(seq * 4);
        cur_r29 = 32'h2900_0000 ^ 32'(seq * 32'h0001_0101);
        cur_r30 = 32'h3000_0000 ^ 32'(seq * 32'h0002_0303);
        cur_bsr = 32'h5500_0000 ^ 32'(seq * 32'h0004_0707);
        exc_req = is_exc; sw_req = !is_exc || also_sw;
        exc_type = typ; sw_mode = smode; hivec = hv;
        // expected from R2/R3/R4
        case (typ)
            3'd0: begin tgt = 5'h13; vec = 32'h08; end
            3'd1: begin tgt = 5'h17; vec = 32'h0C; end
            3'd2: begin tgt = 5'h17; vec = 32'h10; end
            3'd3: begin tgt = 5'h12; vec = 32'h18; end
            default: begin tgt = 5'h00; vec = 32'h0; end
        endcase
        if (hv) vec = vec + 32'hFFFF_0000;
        if (!is_exc) tgt = smode;
        ob = bank_of(oldm);
        nb = bank_of(tgt);
        ok = (ob >= 0) && (nb >= 0) && (!is_exc || typ < 3'd4);
        if (ok) begin
            if (tgt != oldm) begin // R7
                m_r29[ob] = cur_r29; m_r30[ob] = cur_r30; m_bsr[ob] = cur_bsr;
                e_r29 = m_r29[nb]; e_r30 = m_r30[nb]; e_bsr = m_bsr[nb];
            end else begin          // R8
                e_r29 = cur_r29; e_r30 = cur_r30; e_bsr = cur_bsr;
            end
            e_status = {st[31:5], tgt};
            if (is_exc) begin
                e_status[7] = 1'b1;
                e_bsr = st;
                e_r30 = cur_pc;
                e_pc  = vec;
            end else begin
                e_pc = cur_pc;
            end
        end
        @(negedge clk);
        exc_req = 1'b0; sw_req = 1'b0;
        chk(ok ? "R10 done" : "R11 done", {31'd0, done}, {31'd0, ok});
        chk(ok ? "R10 err" : "R11 err", {31'd0, err}, {31'd0, !ok});
        chk(is_exc ? "R5 status" : "R9 status", out_status, e_status);
        chk(is_exc ? "R6/R4 pc" : "R9 pc", out_pc, e_pc);
        chk(is_exc ? "R7/R8 r29" : "R9/R7 r29", out_r29, e_r29);
        chk(is_exc ? "R6 r30" : "R9/R7 r30", out_r30, e_r30);
        chk(is_exc ? "R5 bsr" : "R9/R7 bsr", out_bsr, e_bsr);
        @(negedge clk);
        chk("R10 idle", {30'd0, done, err}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 5; b++) begin m_r29[b] = '0; m_r30[b] = '0; m_bsr[b] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done/err", {30'd0, done, err}, 32'd0);
        chk("R1 status", out_status, 32'd0);
        chk("R1 pc", out_pc, 32'd0);
        chk("R1 regs", out_r29 | out_r30 | out_bsr, 32'd0);
        rst_n = 1'b1;
        // R2/R3/R4: every known mode x type x vector setting
        for (int m = 0; m < 6; m++)
            for (int t = 0; t < 4; t++)
                for (int h = 0; h < 2; h++)
                    op(1'b1, 1'b0, 3'(t), 5'h0, modes[m], h[0]);
        // R9: every plain switch pair, reading banks back (R7, R8)
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                op(1'b0, 1'b0, 3'd0, modes[b], modes[a], 1'b0);
        // R11: unknown type codes, unknown current mode, unknown target
        for (int t = 4; t < 8; t++) op(1'b1, 1'b0, 3'(t), 5'h0, 5'h13, 1'b1);
        op(1'b1, 1'b0, 3'd3, 5'h0, 5'h00, 1'b0);
        op(1'b1, 1'b0, 3'd0, 5'h0, 5'h11, 1'b0);
        op(1'b0, 1'b0, 3'd0, 5'h15, 5'h10, 1'b0);
        op(1'b0, 1'b0, 3'd0, 5'h13, 5'h1C, 1'b0);
        // R12: exception wins over a simultaneous switch
        op(1'b1, 1'b1, 3'd2, 5'h1B, 5'h10, 1'b0);
        op(1'b1, 1'b1, 3'd3, 5'h10, 5'h13, 1'b1);
        // bank contents after the priority case, read back through a switch
        op(1'b0, 1'b0, 3'd0, 5'h17, 5'h12, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule